// File: doc/BRIEF.md
# Multi-Channel H-Bridge Driver Supervisor

This block sits beside six H-bridge channel controllers and decides, cycle by cycle, whether the driver is asleep, whether a protection fault has shut every channel down, and whether the two current-capable channels may run in current-chopping mode. It watches the twelve direction inputs (two per channel), a shared current-mode select for the last two channels, and two digital flags from the analog under-voltage detector and the temperature sensor.

Sleep is implicit. When every direction input is low, the supervisor raises `standby`, the channels go high-impedance, and both protection paths are disarmed and cleared. Any input going high ends sleep at once. Protection is re-armed only after a wake-up settle window. Each flag must hold its level for a filter length before a fault trips or releases. While a fault is active, `force_off` holds every channel off, whatever the direction inputs do.

Top module: `driver_supervisor`

## Requirements
- R1: After reset, and one clock edge after all twelve direction inputs are sampled low, `standby` is 1 and status bit 0 is 1.
- R2: `standby` returns to 0 on the first clock edge at which any one of the twelve direction inputs is sampled high.
- R3: While asleep, and during the settle window after waking, the under-voltage and over-temperature flags have no effect: status bits 1 and 2 and `force_off` stay 0.
- R4: Protection is armed at the SETTLE_CYC-th edge after waking, where the waking edge is edge 1. SETTLE_CYC is CLK_MHZ*SETTLE_US, which is 200 by default. The flag filters count only from the following edge.
- R5: The under-voltage fault (status bit 1) sets at the FILT_CYC-th consecutive armed edge at which the flag is sampled high. A shorter pulse leaves it clear.
- R6: The over-temperature fault (status bit 2) follows the same FILT_CYC rule. A single low sample restarts its count.
- R7: An active fault clears only after its flag has been sampled low on FILT_CYC consecutive edges.
- R8: `force_off` is 1 whenever either fault is active, and changing the direction inputs among non-idle patterns does not clear it.
- R9: If all direction inputs go low while a fault is active, the fault and `force_off` clear on the same edge at which `standby` rises.
- R10: Both bits of `cur_mode_en` equal the current-mode select as sampled one edge earlier, and they are 0 while `standby` or `force_off` is 1.
- R11: `status` is {over-temperature fault, under-voltage fault, standby}, from bit 2 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_in | input | 12 | Direction inputs, two per channel |
| cur_sel | input | 1 | Current-chopping select for the current-capable channels |
| uv_flag | input | 1 | Supply-low flag from the analog detector |
| ot_flag | input | 1 | Over-temperature flag from the sensor |
| standby | output | 1 | Driver asleep, all outputs high-impedance |
| force_off | output | 1 | Global shut-off for every channel |
| cur_mode_en | output | 2 | Current-mode enable, one bit per current-capable channel |
| status | output | 3 | {ot fault, uv fault, standby} |

## Verification
`standby` changes at the first edge after the direction inputs change, and `cur_mode_en` follows `cur_sel` one edge later. A fault trips no earlier than edge SETTLE_CYC+FILT_CYC after waking, and it releases FILT_CYC edges after its flag drops. The bench drives inputs at the falling edge and counts exactly the rising edges each result needs. It samples 2 ns after the last counted edge and also checks the cycle just before a trip, so a result that arrives one cycle early or late is caught.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef struct packed {
        logic ot_fault;
        logic uv_fault;
        logic standby;
    } sup_status_t;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_UV   = 0;
    localparam int FLAG_OT   = 1;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/sup_wake_timer.sv
module sup_wake_timer
    import sup_pkg::*;
#(
    parameter int SETTLE_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic all_low_i,
    output logic standby_o,
    output logic armed_o
);
    localparam int CW = cnt_width(SETTLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            standby_o <= 1'b1;
            armed_o   <= 1'b0;
            cnt_q     <= '0;
        end else if (all_low_i) begin
            standby_o <= 1'b1;
            armed_o   <= 1'b0;
            cnt_q     <= '0;
        end else begin
            standby_o <= 1'b0;
            if (!armed_o) begin
                if (cnt_q == LAST) armed_o <= 1'b1;
                else               cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // R3: protection is never armed while asleep
    assert_sleep_disarm_R3: assert property (@(posedge clk) disable iff (rst)
        standby_o |-> !armed_o);

    // R4: arming only happens in the awake state
    assert_arm_awake_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_o) |-> !standby_o);

endmodule

// File: rtl/sup_flag_filter.sv
module sup_flag_filter
    import sup_pkg::*;
#(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic flag_i,
    output logic fault_o
);
    localparam int CW = cnt_width(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q   <= '0;
            fault_o <= 1'b0;
        end else if (flag_i != fault_o) begin
            if (cnt_q == LAST) begin
                fault_o <= flag_i;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // R5: a trip needs an armed, asserted flag on the tripping edge
    assert_trip_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> $past(flag_i && en_i));

    // R7: a release needs a low flag or a disarm on the releasing edge
    assert_release_needs_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_o) |-> $past(!flag_i || !en_i));

endmodule

// File: rtl/driver_supervisor.sv
module driver_supervisor
    import sup_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int IN_PER_CH = 2,
    parameter int NUM_CUR   = 2,
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_US = 2,
    parameter int FILT_CYC  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CH*IN_PER_CH-1:0] ctl_in,
    input  logic                        cur_sel,
    input  logic                        uv_flag,
    input  logic                        ot_flag,
    output logic                        standby,
    output logic                        force_off,
    output logic [NUM_CUR-1:0]          cur_mode_en,
    output logic [2:0]                  status
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

    logic                 all_low;
    logic                 armed;
    logic                 prot_en;
    logic                 sel_q;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] faults;
    sup_status_t          stat;

    assign all_low = ~|ctl_in;

    sup_wake_timer #(.SETTLE_CYC(SETTLE_CYC)) u_wake (
        .clk       (clk),
        .rst       (rst),
        .all_low_i (all_low),
        .standby_o (standby),
        .armed_o   (armed)
    );

    // Disarm on the same edge that sleep begins
    assign prot_en = armed & ~all_low;

    assign flags[FLAG_UV] = uv_flag;
    assign flags[FLAG_OT] = ot_flag;

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_filt
        sup_flag_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .en_i    (prot_en),
            .flag_i  (flags[f]),
            .fault_o (faults[f])
        );
    end

    assign force_off = |faults;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= cur_sel;
    end

    for (genvar c = 0; c < NUM_CUR; c++) begin : g_cur
        assign cur_mode_en[c] = sel_q & ~standby & ~force_off;
    end

    always_comb begin
        stat.standby  = standby;
        stat.uv_fault = faults[FLAG_UV];
        stat.ot_fault = faults[FLAG_OT];
    end
    assign status = stat;

    // R3: asleep implies no shut-off from protection
    assert_asleep_no_fault_R3: assert property (@(posedge clk) disable iff (rst)
        standby |-> !force_off);

    // R10: current mode only follows a previously sampled select
    assert_cur_follows_sel_R10: assert property (@(posedge clk) disable iff (rst)
        cur_mode_en[0] |-> $past(cur_sel));

endmodule

// File: tb/tb_driver_supervisor.sv
module tb_driver_supervisor;

    typedef struct packed {
        logic [11:0] ctl;
        logic        sel;
        logic        uv;
        logic        ot;
        logic [15:0] cyc;
        logic [2:0]  stat;
        logic        frc;
        logic [1:0]  cur;
    } vec_t;

    localparam int NV = 14;
    // Cumulative edges since wake: armed at 200, trips counted from 201
    localparam vec_t VEC [NV] = '{
        '{12'h000, 1'b0, 1'b0, 1'b0, 16'd2,   3'b001, 1'b0, 2'b00}, // R1 asleep
        '{12'h001, 1'b0, 1'b1, 1'b0, 16'd1,   3'b000, 1'b0, 2'b00}, // R2 wake, R3 uv ignored
        '{12'h001, 1'b0, 1'b1, 1'b0, 16'd100, 3'b000, 1'b0, 2'b00}, // R3 settle window
        '{12'h001, 1'b0, 1'b1, 1'b0, 16'd102, 3'b000, 1'b0, 2'b00}, // R4 edge 203 not yet
        '{12'h001, 1'b0, 1'b1, 1'b0, 16'd1,   3'b010, 1'b1, 2'b00}, // R4 R5 trip at 204
        '{12'h800, 1'b1, 1'b1, 1'b0, 16'd2,   3'b010, 1'b1, 2'b00}, // R8 R10 held off
        '{12'h800, 1'b1, 1'b0, 1'b0, 16'd3,   3'b010, 1'b1, 2'b00}, // R7 not yet
        '{12'h800, 1'b1, 1'b0, 1'b0, 16'd1,   3'b000, 1'b0, 2'b11}, // R7 R10 released
        '{12'h800, 1'b1, 1'b0, 1'b1, 16'd3,   3'b000, 1'b0, 2'b11}, // R6 short pulse
        '{12'h800, 1'b1, 1'b0, 1'b0, 16'd1,   3'b000, 1'b0, 2'b11}, // R6 restart
        '{12'h800, 1'b1, 1'b0, 1'b1, 16'd3,   3'b000, 1'b0, 2'b11}, // R6 counting again
        '{12'h800, 1'b1, 1'b0, 1'b1, 16'd1,   3'b100, 1'b1, 2'b00}, // R6 R11 ot trip
        '{12'h000, 1'b1, 1'b0, 1'b1, 16'd1,   3'b001, 1'b0, 2'b00}, // R9 sleep clears
        '{12'h000, 1'b1, 1'b1, 1'b1, 16'd5,   3'b001, 1'b0, 2'b00}  // R3 flags ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ctl_in = '0;
    logic        cur_sel = 1'b0;
    logic        uv_flag = 1'b0;
    logic        ot_flag = 1'b0;
    logic        standby;
    logic        force_off;
    logic [1:0]  cur_mode_en;
    logic [2:0]  status;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    driver_supervisor dut (
        .clk         (clk),
        .rst         (rst),
        .ctl_in      (ctl_in),
        .cur_sel     (cur_sel),
        .uv_flag     (uv_flag),
        .ot_flag     (ot_flag),
        .standby     (standby),
        .force_off   (force_off),
        .cur_mode_en (cur_mode_en),
        .status      (status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        edges(3);
        chk("R1 reset standby", {7'd0, standby}, 8'd1);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctl_in  = VEC[i].ctl;
            cur_sel = VEC[i].sel;
            uv_flag = VEC[i].uv;
            ot_flag = VEC[i].ot;
            edges(int'(VEC[i].cyc));
            chk($sformatf("R11 status vec%0d", i), {5'd0, status}, {5'd0, VEC[i].stat});
            chk($sformatf("R8 force_off vec%0d", i), {7'd0, force_off}, {7'd0, VEC[i].frc});
            chk($sformatf("R10 cur_mode_en vec%0d", i), {6'd0, cur_mode_en}, {6'd0, VEC[i].cur});
        end

        // R1: reset wins over an active input pattern and raised flags
        @(negedge clk);
        rst = 1'b1; ctl_in = 12'h001; uv_flag = 1'b1; ot_flag = 1'b1; cur_sel = 1'b0;
        edges(2);
        chk("R1 reset status", {5'd0, status}, 8'h01);
        @(negedge clk);
        rst = 1'b0;
        edges(1);
        chk("R2 wake after reset", {5'd0, status}, 8'h00);

        // R2/R1: each single input wakes the driver, all low returns to sleep
        for (int b = 0; b < 12; b++) begin
            @(negedge clk);
            ctl_in = 12'h000;
            edges(1);
            chk($sformatf("R1 sleep bit%0d", b), {7'd0, standby}, 8'd1);
            @(negedge clk);
            ctl_in = 12'h001 << b;
            edges(1);
            chk($sformatf("R2 wake bit%0d", b), {7'd0, standby}, 8'd0);
        end

        // R10: select is masked while asleep, passed once awake
        @(negedge clk);
        ctl_in = 12'h000; uv_flag = 1'b0; ot_flag = 1'b0; cur_sel = 1'b1;
        edges(3);
        chk("R10 cur masked asleep", {6'd0, cur_mode_en}, 8'h00);
        @(negedge clk);
        ctl_in = 12'h040;
        edges(1);
        chk("R10 cur enabled awake", {6'd0, cur_mode_en}, 8'h03);
        @(negedge clk);
        cur_sel = 1'b0;
        edges(1);
        chk("R10 cur follows select", {6'd0, cur_mode_en}, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule